// File: doc/BRIEF.md
# Dual-Channel Synthesizer Serial Load Port

This block accepts configuration words for a two-channel frequency synthesizer over three wires: a serial data line, a serial clock and a latch strobe. Bits enter a staging shift register one per rising edge of the serial clock, most significant bit first. The last two bits of every frame are a two-bit address. The first twenty bits are the payload.

A rising edge of the latch strobe copies the staged payload into one of four holding registers. The address selects the register: the reference divider word or the programmable divider word of channel one or channel two. All four holding registers drive parallel outputs. The block also decodes the output-mode field and the charge-pump current bit of each reference word onto their own pins.

The three serial wires are sampled by the block's own clock. The block detects their edges there, so the serial clock must run well below the system clock.

Top module: `synth_serial_loader`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge of `clk`, clears all four holding registers and the staging register to zero.
- R2: A frame is 22 bits, shifted most significant bit first. The first 20 bits are data bit 20 down to data bit 1, and the last two bits are address bit A1 then address bit A0. Data bit k appears at bit k-1 of the holding register output.
- R3: The address selects the destination: A1A0 = 00 loads `rf1_ref_word`, 01 loads `rf1_prog_word`, 10 loads `rf2_ref_word` and 11 loads `rf2_prog_word`. The other three registers keep their values.
- R4: Shifting bits with the latch strobe low never changes any holding register.
- R5: A load happens only on a rising edge of `ser_le`. Bits shifted while the strobe stays high do not load until the strobe rises again.
- R6: When more than 22 bits are shifted before a strobe, only the last 22 bits form the frame.
- R7: `rfN_out_mode` equals {data bit 20, data bit 19} of channel N's reference word, and `rfN_cp_high` equals data bit 17 of that word.
- R8: Input timing rules: `ser_data` is stable at each rising edge of `ser_clk`, and `ser_le` stays high for at least two `clk` cycles. A strobe of exactly that minimum width loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock; shifts on its rising edge |
| ser_le | input | 1 | Latch strobe; loads on its rising edge |
| rf1_ref_word | output | 20 | Channel 1 reference divider word |
| rf1_prog_word | output | 20 | Channel 1 programmable divider word |
| rf2_ref_word | output | 20 | Channel 2 reference divider word |
| rf2_prog_word | output | 20 | Channel 2 programmable divider word |
| rf1_out_mode | output | 2 | Channel 1 output-mode field {bit 20, bit 19} |
| rf1_cp_high | output | 1 | Channel 1 charge-pump current bit (bit 17) |
| rf2_out_mode | output | 2 | Channel 2 output-mode field {bit 20, bit 19} |
| rf2_cp_high | output | 1 | Channel 2 charge-pump current bit (bit 17) |

## Verification
The bench sends asymmetric payloads to every address and checks all four registers after each load. A swapped address decode or a reversed bit order therefore shows up as a wrong word or as a neighbour that is overwritten. It shifts a frame with the strobe low, and a second frame while the strobe is held high. A design that loads on strobe level, or on every shift, would change a register in either case. It also prefixes a frame with extra bits, which a design that latches the first 22 bits instead of the last would get wrong. Last, it uses a strobe of the minimum width and decodes the mode and charge-pump fields, where an off-by-one bit index would show.

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
  parameter int DATA_W  = 20,
  parameter int MODE_HI = 20,
  parameter int MODE_LO = 19,
  parameter int CP_BIT  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_le,
  output logic [DATA_W-1:0] rf1_ref_word,
  output logic [DATA_W-1:0] rf1_prog_word,
  output logic [DATA_W-1:0] rf2_ref_word,
  output logic [DATA_W-1:0] rf2_prog_word,
  output logic [1:0]        rf1_out_mode,
  output logic              rf1_cp_high,
  output logic [1:0]        rf2_out_mode,
  output logic              rf2_cp_high
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int NREG    = 4;

  logic sclk_q, sclk_qq, le_q, le_qq, dat_q;
  logic clk_edge, le_edge;
  logic [FRAME_W-1:0] stage;
  logic [DATA_W-1:0]  word_r [NREG];

  assign clk_edge = sclk_q & ~sclk_qq;
  assign le_edge  = le_q & ~le_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      le_q    <= 1'b0;
      le_qq   <= 1'b0;
      dat_q   <= 1'b0;
      stage   <= '0;
      for (int i = 0; i < NREG; i++) word_r[i] <= '0;
    end else begin
      sclk_q  <= ser_clk;
      sclk_qq <= sclk_q;
      le_q    <= ser_le;
      le_qq   <= le_q;
      dat_q   <= ser_data;
      if (clk_edge) stage <= {stage[FRAME_W-2:0], dat_q};
      if (le_edge) word_r[stage[1:0]] <= stage[FRAME_W-1:2];
    end
  end

  assign rf1_ref_word  = word_r[0];
  assign rf1_prog_word = word_r[1];
  assign rf2_ref_word  = word_r[2];
  assign rf2_prog_word = word_r[3];

  assign rf1_out_mode = {word_r[0][MODE_HI-1], word_r[0][MODE_LO-1]};
  assign rf1_cp_high  = word_r[0][CP_BIT-1];
  assign rf2_out_mode = {word_r[2][MODE_HI-1], word_r[2][MODE_LO-1]};
  assign rf2_cp_high  = word_r[2][CP_BIT-1];
endmodule

module synth_serial_loader_chk #(
  parameter int DATA_W = 20,
  parameter int LE_MIN = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                ser_data,
  input logic                ser_clk,
  input logic                ser_le,
  input logic                le_edge,
  input logic [DATA_W+1:0]   stage,
  input logic [DATA_W-1:0]   w0,
  input logic [DATA_W-1:0]   w1,
  input logic [DATA_W-1:0]   w2,
  input logic [DATA_W-1:0]   w3
);
  localparam int FRAME_W = DATA_W + 2;

  logic [7:0] le_cnt;
  always_ff @(posedge clk) begin
    if (rst) le_cnt <= '0;
    else if (ser_le) le_cnt <= (le_cnt == 8'hFF) ? le_cnt : le_cnt + 8'd1;
    else le_cnt <= '0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (w0 == '0 && w1 == '0 && w2 == '0 && w3 == '0));

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(le_edge) && !$past(rst)) |->
      ($stable(w0) && $stable(w1) && $stable(w2) && $stable(w3)));

  // R3
  load_rf1_ref_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(le_edge) && !$past(rst) && $past(stage[1:0]) == 2'b00) |->
      (w0 == $past(stage[FRAME_W-1:2])));

  // R3
  load_rf2_prog_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(le_edge) && !$past(rst) && $past(stage[1:0]) == 2'b11) |->
      (w3 == $past(stage[FRAME_W-1:2]) && $stable(w0) && $stable(w1) && $stable(w2)));

  // R8
  data_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_data));

  // R8
  le_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_le) |-> (le_cnt >= 8'(LE_MIN)));
endmodule

bind synth_serial_loader synth_serial_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
  .le_edge(le_edge), .stage(stage),
  .w0(rf1_ref_word), .w1(rf1_prog_word), .w2(rf2_ref_word), .w3(rf2_prog_word)
);

// File: tb/tb_synth_serial_loader.sv
`timescale 1ns/1ps
module tb_synth_serial_loader;
  logic clk = 1'b0;
  logic rst, ser_data, ser_clk, ser_le;
  logic [19:0] rf1_ref_word, rf1_prog_word, rf2_ref_word, rf2_prog_word;
  logic [1:0]  rf1_out_mode, rf2_out_mode;
  logic        rf1_cp_high, rf2_cp_high;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [19:0] exp_w [4];

  always #4 clk = ~clk;

  synth_serial_loader dut (
    .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
    .rf1_ref_word(rf1_ref_word), .rf1_prog_word(rf1_prog_word),
    .rf2_ref_word(rf2_ref_word), .rf2_prog_word(rf2_prog_word),
    .rf1_out_mode(rf1_out_mode), .rf1_cp_high(rf1_cp_high),
    .rf2_out_mode(rf2_out_mode), .rf2_cp_high(rf2_cp_high)
  );

  localparam logic [21:0] VEC [0:5] = '{
    {20'hA5A5A, 2'd0}, {20'h12345, 2'd1}, {20'hFFFFF, 2'd2},
    {20'h00001, 2'd3}, {20'h80000, 2'd0}, {20'h5A5A5, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " rf1_ref"},  32'(rf1_ref_word),  32'(exp_w[0]));
    chk({req, " rf1_prog"}, 32'(rf1_prog_word), 32'(exp_w[1]));
    chk({req, " rf2_ref"},  32'(rf2_ref_word),  32'(exp_w[2]));
    chk({req, " rf2_prog"}, 32'(rf2_prog_word), 32'(exp_w[3]));
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      @(negedge clk);
      ser_clk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      ser_clk = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_le(input int hi);
    ser_le = 1'b1;
    repeat (hi) @(negedge clk);
    ser_le = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load(input logic [21:0] f);
    send_bits(64'(f), 22);
    pulse_le(3);
    exp_w[f[1:0]] = f[21:2];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ser_data = 1'b0; ser_clk = 1'b0; ser_le = 1'b0;
    for (int i = 0; i < 4; i++) exp_w[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 reset");

    // R2/R3: table walk over all addresses
    for (int v = 0; v < 6; v++) begin
      load(VEC[v]);
      chk_all("R2/R3 vector");
    end

    // R2: data bit 1 lands at output bit 0
    chk("R2 lsb", 32'(rf2_prog_word), 32'h1);

    // R7: mode {bit20,bit19} and charge-pump bit17 of the reference words
    chk("R7 rf1 mode", 32'(rf1_out_mode), 32'({exp_w[0][19], exp_w[0][18]}));
    chk("R7 rf1 cp",   32'(rf1_cp_high),  32'(exp_w[0][16]));
    chk("R7 rf2 mode", 32'(rf2_out_mode), 32'({exp_w[2][19], exp_w[2][18]}));
    chk("R7 rf2 cp",   32'(rf2_cp_high),  32'(exp_w[2][16]));

    // R4: shifting without strobe changes nothing
    send_bits(64'({20'h0BEEF, 2'd1}), 22);
    chk_all("R4 shift no strobe");

    // R5: strobe held high while a new frame shifts, then released
    ser_le = 1'b1;
    repeat (3) @(negedge clk);
    exp_w[1] = 20'h0BEEF;
    send_bits(64'({20'h33333, 2'd3}), 22);
    ser_le = 1'b0;
    repeat (2) @(negedge clk);
    chk_all("R5 strobe held high");
    pulse_le(3);
    exp_w[3] = 20'h33333;
    chk_all("R5 new rising strobe");

    // R6: extra leading bits are discarded
    send_bits(64'hA5, 8);
    load({20'h0F0F0, 2'd1});
    chk_all("R6 overlong shift");

    // R8: minimum strobe width loads
    send_bits(64'({20'h6C6C6, 2'd2}), 22);
    pulse_le(2);
    exp_w[2] = 20'h6C6C6;
    chk_all("R8 min strobe");

    // R1: reset after loads
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) exp_w[i] = '0;
    chk_all("R1 reset after load");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule